// File: doc/BRIEF.md
# Latched Scrambled-Word Memory Wrapper

This block wraps a small synchronous single-port memory behind a 72-bit word interface, 64 data bits and 8 check bits, with an address and a write request. Every request first passes through a staging register that holds the write request, the address and the data. The write only reaches the storage array on the following enabled clock edge. The check bits are not computed or checked here; they are kept and returned exactly as written.

Inside the array, the bits of a word do not sit in logical order. Logical bit i lives at physical column (i*STRIDE + OFFSET) mod 72, a fixed spread chosen to ease wiring. The read path undoes exactly that mapping, so callers never see the scrambled order. A clock-enable input lets the system freeze the whole block, for example while a scan operation runs, and resume it later. Freezing and resuming must neither add a write nor let a read show a word from an address other than the one requested.

Top module: `sram_latch_wrap`

## Requirements
- R1: The word is 72 bits wide; bits 63:0 are data and bits 71:64 are check bits, and both fields are stored and returned unchanged.
- R2: Any 72-bit pattern written to an address reads back bit-identical, including every single-bit pattern, because the read-side unscramble is the exact inverse of the write-side scramble.
- R3: A write presented on enabled edge k is captured by the staging register and written into the array on the next enabled edge k+1; a read of the same address presented on edge k+1 returns the previous contents, and one presented on edge k+2 returns the new word.
- R4: rdata shows the word stored at the address presented on the most recent enabled clock edge.
- R5: While rst_n is low and after its release, before any enabled edge, rdata is all zeros and no write is pending.
- R6: While clk_en is low, the staging register, the array and the read register hold their state, rdata stays constant, and changes on wr_en, addr and wdata have no effect.
- R7: A write still pending in the staging register when the clock stops commits exactly once on the first enabled edge after restart, and requests presented only while clk_en was low are never written.
- R8: When the clock restarts after a stop, the first rdata comes from the address presented on the restart edge, with no cycle showing data from an address that was presented only during the stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of staging and read registers |
| clk_en | input | 1 | Clock enable; low freezes the whole block |
| wr_en | input | 1 | Write request for the presented address and word |
| addr | input | ADDR_W | Word address for read and write |
| wdata | input | 72 | Write word, data in 63:0 and check bits in 71:64 |
| rdata | output | 72 | Read word in logical bit order |

## Verification
The delayed commit of a staged write and a read of the same address can happen on the same edge. The bench provokes this by presenting a write and then, on the very next cycle, a read of that address. It expects the old word on that cycle and the new word one cycle later. A clock stop can also land while a write sits in the staging register. The bench stops the clock with a write pending, changes all request inputs to a different address during the stop, and then restarts. It judges the result by reading both addresses back against its own model.

// File: rtl/sram_latch_wrap.sv
module sram_latch_wrap #(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int ADDR_W = 4,
  parameter int STRIDE = 5,
  parameter int OFFSET = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W+CHK_W-1:0]  wdata,
  output logic [DATA_W+CHK_W-1:0]  rdata
);
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic int phys_pos(input int i);
    return (i * STRIDE + OFFSET) % WORD_W;
  endfunction

  function automatic word_t scramble(input word_t w);
    word_t p = '0;
    for (int i = 0; i < WORD_W; i++) p[phys_pos(i)] = w[i];
    return p;
  endfunction

  function automatic word_t unscramble(input word_t p);
    word_t w = '0;
    for (int i = 0; i < WORD_W; i++) w[i] = p[phys_pos(i)];
    return w;
  endfunction

  logic              st_we;
  logic [ADDR_W-1:0] st_addr;
  word_t             st_data;
  word_t             rd_q;
  word_t             mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_we   <= 1'b0;
      st_addr <= '0;
      st_data <= '0;
      rd_q    <= '0;
    end else if (clk_en) begin
      st_we   <= wr_en;
      st_addr <= addr;
      st_data <= scramble(wdata);
      rd_q    <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && st_we) mem[st_addr] <= st_data;
  end

  assign rdata = unscramble(rd_q);

  always_comb begin
    if (rst_n && !$isunknown(wdata))
      assert_perm_roundtrip_R2: assert (unscramble(scramble(wdata)) == wdata);
  end

  assert_stopped_rdata_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(rdata));

  assert_stopped_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(st_we) && $stable(st_addr) && $stable(st_data)));

  assert_stage_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && wr_en) |=> (st_we && st_addr == $past(addr)));

  assert_write_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && st_we) |=> (!st_we || $past(wr_en)));
endmodule

// File: tb/sram_latch_wrap_tb_top.sv
module sram_latch_wrap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [71:0] wdata = '0;
  logic [71:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [71:0] model [16];

  sram_latch_wrap dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [71:0] d);
    clk_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic do_read(input string req, input logic [3:0] a);
    clk_en = 1'b1; wr_en = 1'b0; addr = a;
    step();
    chk(req, rdata, model[a]);
  endtask

  function automatic logic [71:0] pat(input int a, input int s);
    logic [63:0] d = 64'h9E37_79B9_7F4A_7C15 * (a + 1) ^ {32'(s), 32'(a * 77 + s)};
    logic [7:0]  c = 8'(a * 29 + s * 3) ^ 8'hA5;
    return {c, d};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; clk_en = 1'b1;
    step(); step();
    chk("R5 rdata during reset", rdata, '0);
    rst_n = 1'b1;
    #1;
    chk("R5 rdata after release", rdata, '0);
  endtask

  task automatic t_fill(input int s);
    for (int a = 0; a < 16; a++) do_write(4'(a), pat(a, s));
    step();
    for (int a = 0; a < 16; a++) do_read("R2 R4 fill readback", 4'(a));
  endtask

  task automatic t_fields();
    do_write(4'd9, {8'hC3, 64'h0000_0000_FFFF_0000});
    step();
    addr = 4'd9; step();
    chk("R1 data field", {8'h00, rdata[63:0]}, {8'h00, 64'h0000_0000_FFFF_0000});
    chk("R1 check field", {64'h0, rdata[71:64]}, {64'h0, 8'hC3});
  endtask

  task automatic t_walk();
    for (int b = 0; b < 72; b++) begin
      do_write(4'd5, 72'd1 << b);
      step();
      do_read("R2 walking one", 4'd5);
    end
    do_write(4'd5, '1);
    step();
    do_read("R2 all ones", 4'd5);
  endtask

  task automatic t_delay();
    logic [71:0] oldv = model[4'd7];
    logic [71:0] newv = pat(7, 99);
    clk_en = 1'b1; wr_en = 1'b1; addr = 4'd7; wdata = newv;
    step();
    wr_en = 1'b0; addr = 4'd7;
    step();
    chk("R3 same-edge read sees old", rdata, oldv);
    step();
    chk("R3 next read sees new", rdata, newv);
    model[4'd7] = newv;
  endtask

  task automatic t_stop_pending();
    logic [71:0] held;
    logic [71:0] wv = pat(2, 55);
    do_read("R4 before stop", 4'd11);
    clk_en = 1'b1; wr_en = 1'b1; addr = 4'd2; wdata = wv;
    step();
    held = rdata;
    clk_en = 1'b0; wr_en = 1'b1; addr = 4'd11; wdata = pat(11, 77);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R6 rdata frozen", rdata, held);
      wdata = pat(11, 78 + i);
    end
    clk_en = 1'b1; wr_en = 1'b0; addr = 4'd11;
    step();
    chk("R7 stopped request not written", rdata, model[4'd11]);
    model[4'd2] = wv;
    do_read("R7 pending write committed", 4'd2);
    do_read("R7 other address intact", 4'd11);
  endtask

  task automatic t_resume_addr();
    do_read("R4 read before stop", 4'd3);
    clk_en = 1'b0;
    addr = 4'd12;
    step();
    chk("R8 held during stop", rdata, model[4'd3]);
    addr = 4'd13;
    step();
    chk("R8 held during stop, addr moved", rdata, model[4'd3]);
    clk_en = 1'b1; addr = 4'd14;
    step();
    chk("R8 first read after restart", rdata, model[4'd14]);
  endtask

  task automatic t_stop_idle_write();
    do_write(4'd6, pat(6, 200));
    clk_en = 1'b0; wr_en = 1'b1; addr = 4'd6; wdata = pat(6, 201);
    step(); step();
    clk_en = 1'b1; wr_en = 1'b0; addr = 4'd0;
    step();
    do_read("R6 R7 stopped overwrite ignored", 4'd6);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill(1);
    t_fields();
    t_walk();
    t_fill(2);
    t_delay();
    t_stop_pending();
    t_resume_addr();
    t_stop_idle_write();
    t_fill(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule